// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This block is a bus slave that sits behind a 32 MiB alias window and presents every word-sized alias location as a single bit of a source memory region. A read of an alias word performs one downstream read of the containing 1, 2 or 4 bytes. It returns the chosen bit as the value 0 or 1. A write performs a read-modify-write. The bridge reads the containing data, forces the chosen bit to bit 0 of the write data, and writes the data back to the same address with the same size.

Upstream is a plain request/response port. A request is taken in a single cycle while the bridge is idle. The bridge then stays busy until it returns a one-cycle response carrying read data and an error flag. Downstream is a memory master port with a request/ready handshake and a later response strobe that carries data and an error flag. The source region base address is a parameter. The usual pairings place a source base of 0x2000_0000 behind an alias at 0x2200_0000, or a source base of 0x4000_0000 behind an alias at 0x4200_0000.

Top module: `bitband_bridge`

## Requirements
- R1: After reset `up_busy`, `up_rsp_valid` and `dn_req` are all low.
- R2: For alias offset `off` (the low 25 address bits) and access size N bytes, the downstream address is `SRC_BASE | (off >> 5)`, rounded down to a multiple of N. Address bits 25 and above play no part.
- R3: The selected bit is position `p = (off >> 2) & (8N-1)` of the fetched data. That is bit `p & 7` of byte `p >> 3`. Downstream data is right-justified and little-endian, so byte 0 is the lowest address.
- R4: A read response carries the selected bit in bit 0 and zero in every other bit. It issues no downstream write.
- R5: A write sets the selected bit when `up_wdata[0]` is 1 and clears it when 0. It writes the fetched data back with every other bit unchanged, using the same address and size as the read. `up_wdata` bits above bit 0 have no effect.
- R6: Size codes 0, 1 and 2 select 1, 2 and 4 bytes, and the same code is driven on `dn_size`. Code 3 gets an error response and causes no downstream transaction.
- R7: When the downstream read responds with an error, the bridge returns an upstream error response and issues no write.
- R8: When the downstream write responds with an error, the upstream response is an error. Otherwise a completed access responds without error.
- R9: `up_busy` rises the cycle after a request is taken and falls the cycle after the one-cycle response. Requests while busy are ignored.
- R10: While `dn_req` is high and `dn_ready` is low, the downstream request and its address stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_req | input | 1 | Upstream request strobe, taken when not busy |
| up_we | input | 1 | 1 = write, 0 = read |
| up_addr | input | ADDR_W | Alias address; only the low WIN_W bits are decoded |
| up_size | input | 2 | Size code: 0 = 1 B, 1 = 2 B, 2 = 4 B, 3 = illegal |
| up_wdata | input | DATA_W | Write data; bit 0 is the new bit value |
| up_busy | output | 1 | Access in progress |
| up_rsp_valid | output | 1 | One-cycle response strobe |
| up_rsp_rdata | output | DATA_W | Read result (0 or 1) |
| up_rsp_err | output | 1 | Error response |
| dn_req | output | 1 | Downstream request, held until ready |
| dn_we | output | 1 | Downstream write enable |
| dn_addr | output | ADDR_W | Downstream byte address |
| dn_size | output | 2 | Downstream size code |
| dn_wdata | output | DATA_W | Downstream write data, right-justified |
| dn_ready | input | 1 | Downstream accepts the request |
| dn_rvalid | input | 1 | Downstream response strobe |
| dn_rdata | input | DATA_W | Downstream read data, right-justified |
| dn_err | input | 1 | Downstream error flag, valid with dn_rvalid |

## Verification
The assertions assume that the downstream side raises `dn_rvalid` only once for each accepted request, and only in a cycle after the handshake. They also assume `SRC_BASE` is aligned to 1 MiB. The bench's memory model meets both conditions: it answers each handshake after 0 to 1 extra cycles, inserts 0 to 2 cycles of ready stall, and keeps every source index inside its 256-byte array. Error injection is tied to the exact expected downstream address and direction. As a result, an error appears only on the read or write phase the test targets.

// File: rtl/bb_pkg.sv
package bb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_WR_WAIT,
    ST_RESP
  } bb_state_e;

  // Each source byte is spread over 8 alias words of 4 bytes.
  localparam int unsigned BB_SHIFT = 5;
endpackage

// File: rtl/bb_addr_map.sv
module bb_addr_map #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned WIN_W    = 25,
  parameter logic [ADDR_W-1:0] SRC_BASE = 32'h2000_0000,
  localparam int unsigned POS_W   = $clog2(DATA_W)
) (
  input  logic [WIN_W-1:0]  alias_off,
  input  logic [1:0]        size,
  output logic [ADDR_W-1:0] src_addr,
  output logic [POS_W-1:0]  bit_pos,
  output logic              size_ok
);
  import bb_pkg::*;

  localparam int unsigned SZ_MAX = $clog2(DATA_W / 8);

  logic [ADDR_W-1:0] byte_idx;
  logic [ADDR_W-1:0] align_mask;
  logic [POS_W-1:0]  pos_raw;
  logic [POS_W-1:0]  pos_mask;
  logic              unused_low;

  always_comb begin
    byte_idx   = ADDR_W'(alias_off >> BB_SHIFT);
    align_mask = ~((ADDR_W'(1) << size) - ADDR_W'(1));
    src_addr   = (SRC_BASE | byte_idx) & align_mask;
    pos_raw    = alias_off[POS_W+1:2];
    pos_mask   = POS_W'((32'd8 << size) - 32'd1);
    bit_pos    = pos_raw & pos_mask;
    size_ok    = (32'(size) <= SZ_MAX);
  end

  assign unused_low = ^alias_off[1:0];
endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned POS_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] rd_data,
  input  logic [POS_W-1:0]  pos,
  input  logic              new_bit,
  output logic              cur_bit,
  output logic [DATA_W-1:0] merged
);
  assign cur_bit = rd_data[pos];

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    assign merged[i] = (pos == POS_W'(i)) ? new_bit : rd_data[i];
  end
endmodule

// File: rtl/bb_seq.sv
module bb_seq #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned POS_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_req,
  input  logic              up_we,
  input  logic              up_wbit,
  input  logic [1:0]        up_size,
  input  logic [ADDR_W-1:0] map_addr,
  input  logic [POS_W-1:0]  map_pos,
  input  logic              map_size_ok,
  input  logic              cur_bit,
  input  logic [DATA_W-1:0] merged,
  output logic [POS_W-1:0]  pos_q,
  output logic              wbit_q,
  output logic              busy,
  output logic              rsp_valid,
  output logic              rsp_bit,
  output logic              rsp_err,
  output logic              dn_req,
  output logic              dn_we,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [1:0]        dn_size,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic              dn_ready,
  input  logic              dn_rvalid,
  input  logic              dn_err
);
  import bb_pkg::*;

  bb_state_e state;
  logic      we_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      busy      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_bit   <= 1'b0;
      rsp_err   <= 1'b0;
      dn_req    <= 1'b0;
      dn_we     <= 1'b0;
      dn_addr   <= '0;
      dn_size   <= '0;
      dn_wdata  <= '0;
      pos_q     <= '0;
      wbit_q    <= 1'b0;
      we_q      <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (up_req) begin
            busy    <= 1'b1;
            we_q    <= up_we;
            wbit_q  <= up_wbit;
            pos_q   <= map_pos;
            dn_addr <= map_addr;
            dn_size <= up_size;
            if (!map_size_ok) begin
              rsp_err   <= 1'b1;
              rsp_bit   <= 1'b0;
              rsp_valid <= 1'b1;
              state     <= ST_RESP;
            end else begin
              dn_req <= 1'b1;
              dn_we  <= 1'b0;
              state  <= ST_RD_REQ;
            end
          end
        end
        ST_RD_REQ: begin
          if (dn_ready) begin
            dn_req <= 1'b0;
            state  <= ST_RD_WAIT;
          end
        end
        ST_RD_WAIT: begin
          if (dn_rvalid) begin
            if (dn_err) begin
              rsp_err   <= 1'b1;
              rsp_bit   <= 1'b0;
              rsp_valid <= 1'b1;
              state     <= ST_RESP;
            end else if (we_q) begin
              dn_wdata <= merged;
              dn_req   <= 1'b1;
              dn_we    <= 1'b1;
              state    <= ST_WR_REQ;
            end else begin
              rsp_err   <= 1'b0;
              rsp_bit   <= cur_bit;
              rsp_valid <= 1'b1;
              state     <= ST_RESP;
            end
          end
        end
        ST_WR_REQ: begin
          if (dn_ready) begin
            dn_req <= 1'b0;
            state  <= ST_WR_WAIT;
          end
        end
        ST_WR_WAIT: begin
          if (dn_rvalid) begin
            rsp_err   <= dn_err;
            rsp_bit   <= 1'b0;
            rsp_valid <= 1'b1;
            state     <= ST_RESP;
          end
        end
        ST_RESP: begin
          busy  <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WIN_W  = 25,
  parameter logic [ADDR_W-1:0] SRC_BASE = 32'h2000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_req,
  input  logic              up_we,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [1:0]        up_size,
  input  logic [DATA_W-1:0] up_wdata,
  output logic              up_busy,
  output logic              up_rsp_valid,
  output logic [DATA_W-1:0] up_rsp_rdata,
  output logic              up_rsp_err,
  output logic              dn_req,
  output logic              dn_we,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [1:0]        dn_size,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic              dn_ready,
  input  logic              dn_rvalid,
  input  logic [DATA_W-1:0] dn_rdata,
  input  logic              dn_err
);
  localparam int unsigned POS_W = $clog2(DATA_W);

  logic [ADDR_W-1:0] map_addr;
  logic [POS_W-1:0]  map_pos;
  logic              map_size_ok;
  logic [POS_W-1:0]  pos_q;
  logic              wbit_q;
  logic              cur_bit;
  logic [DATA_W-1:0] merged;
  logic              rsp_bit;
  logic              unused_hi;

  assign unused_hi = ^{up_wdata[DATA_W-1:1], up_addr[ADDR_W-1:WIN_W]};

  bb_addr_map #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_W(WIN_W), .SRC_BASE(SRC_BASE)
  ) u_map (
    .alias_off (up_addr[WIN_W-1:0]),
    .size      (up_size),
    .src_addr  (map_addr),
    .bit_pos   (map_pos),
    .size_ok   (map_size_ok)
  );

  bb_bit_merge #(.DATA_W(DATA_W)) u_merge (
    .rd_data (dn_rdata),
    .pos     (pos_q),
    .new_bit (wbit_q),
    .cur_bit (cur_bit),
    .merged  (merged)
  );

  bb_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .up_req      (up_req),
    .up_we       (up_we),
    .up_wbit     (up_wdata[0]),
    .up_size     (up_size),
    .map_addr    (map_addr),
    .map_pos     (map_pos),
    .map_size_ok (map_size_ok),
    .cur_bit     (cur_bit),
    .merged      (merged),
    .pos_q       (pos_q),
    .wbit_q      (wbit_q),
    .busy        (up_busy),
    .rsp_valid   (up_rsp_valid),
    .rsp_bit     (rsp_bit),
    .rsp_err     (up_rsp_err),
    .dn_req      (dn_req),
    .dn_we       (dn_we),
    .dn_addr     (dn_addr),
    .dn_size     (dn_size),
    .dn_wdata    (dn_wdata),
    .dn_ready    (dn_ready),
    .dn_rvalid   (dn_rvalid),
    .dn_err      (dn_err)
  );

  assign up_rsp_rdata = {{(DATA_W-1){1'b0}}, rsp_bit};
endmodule

// File: rtl/bb_bridge_chk.sv
module bb_bridge_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WIN_W  = 25,
  parameter logic [ADDR_W-1:0] SRC_BASE = 32'h2000_0000
) (
  input logic              clk,
  input logic              rst,
  input logic              up_busy,
  input logic              up_rsp_valid,
  input logic [DATA_W-1:0] up_rsp_rdata,
  input logic              up_rsp_err,
  input logic              dn_req,
  input logic              dn_we,
  input logic [ADDR_W-1:0] dn_addr,
  input logic [1:0]        dn_size,
  input logic              dn_ready,
  input logic              dn_rvalid,
  input logic              dn_err
);
  localparam int unsigned REGION_SH = WIN_W - 5;

  // R1
  idle_no_dn_req_chk: assert property (@(posedge clk) disable iff (rst)
    !up_busy |-> !dn_req);

  // R2
  dn_in_region_chk: assert property (@(posedge clk) disable iff (rst)
    dn_req |-> ((dn_addr >> REGION_SH) == (SRC_BASE >> REGION_SH)));

  // R2
  dn_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    dn_req |-> ((dn_addr & ((ADDR_W'(1) << dn_size) - ADDR_W'(1))) == '0));

  // R4
  rd_single_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (up_rsp_valid && !up_rsp_err) |-> (up_rsp_rdata[DATA_W-1:1] == '0));

  // R6
  legal_dn_size_chk: assert property (@(posedge clk) disable iff (rst)
    dn_req |-> (dn_size != 2'd3));

  // R7
  rd_err_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_rvalid && dn_err && !dn_we) |=> (up_rsp_valid && up_rsp_err && !dn_req));

  // R8
  wr_err_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_rvalid && dn_err && dn_we) |=> (up_rsp_valid && up_rsp_err));

  // R9
  rsp_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    up_rsp_valid |=> !up_rsp_valid);

  // R9
  rsp_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    up_rsp_valid |-> up_busy);

  // R10
  dn_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_req && !dn_ready) |=> (dn_req && $stable(dn_addr) && $stable(dn_we)));
endmodule

bind bitband_bridge bb_bridge_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_W(WIN_W), .SRC_BASE(SRC_BASE)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .up_busy      (up_busy),
  .up_rsp_valid (up_rsp_valid),
  .up_rsp_rdata (up_rsp_rdata),
  .up_rsp_err   (up_rsp_err),
  .dn_req       (dn_req),
  .dn_we        (dn_we),
  .dn_addr      (dn_addr),
  .dn_size      (dn_size),
  .dn_ready     (dn_ready),
  .dn_rvalid    (dn_rvalid),
  .dn_err       (dn_err)
);

// File: tb/bitband_bridge_tb.sv
module bitband_bridge_tb;
  localparam logic [31:0] SRC   = 32'h2000_0000;
  localparam logic [31:0] ALIAS = 32'h2200_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        up_req = 1'b0, up_we = 1'b0;
  logic [31:0] up_addr = '0, up_wdata = '0;
  logic [1:0]  up_size = '0;
  logic        up_busy, up_rsp_valid, up_rsp_err;
  logic [31:0] up_rsp_rdata;
  logic        dn_req, dn_we, dn_ready;
  logic [31:0] dn_addr, dn_wdata;
  logic [1:0]  dn_size;
  logic        dn_rvalid = 1'b0, dn_err = 1'b0;
  logic [31:0] dn_rdata = '0;

  int checks = 0, fails = 0;
  int rd_hs = 0, wr_hs = 0, hs_count = 0, rsp_pulses = 0, stray = 0;
  logic [31:0] last_rd_addr = '0, last_wr_addr = '0;
  logic [1:0]  last_rd_size = '0, last_wr_size = '0;
  int          err_kind = 0;
  logic [31:0] err_addr = '0;
  logic [7:0]  mem    [256];
  logic [7:0]  shadow [256];
  logic [1:0]  rdy_wait = '0;
  logic        pend = 1'b0;
  int          rsp_cnt = 0;

  always #2.5 clk = ~clk;

  bitband_bridge #(.SRC_BASE(SRC)) u_dut (
    .clk(clk), .rst(rst), .up_req(up_req), .up_we(up_we), .up_addr(up_addr),
    .up_size(up_size), .up_wdata(up_wdata), .up_busy(up_busy),
    .up_rsp_valid(up_rsp_valid), .up_rsp_rdata(up_rsp_rdata), .up_rsp_err(up_rsp_err),
    .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr), .dn_size(dn_size),
    .dn_wdata(dn_wdata), .dn_ready(dn_ready), .dn_rvalid(dn_rvalid),
    .dn_rdata(dn_rdata), .dn_err(dn_err)
  );

  assign dn_ready = dn_req && (rdy_wait == 2'd0);

  // Behavioural downstream memory with variable stall and latency
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 37 + 5);
      rdy_wait  <= '0;
      pend      <= 1'b0;
      dn_rvalid <= 1'b0;
    end else begin
      dn_rvalid <= 1'b0;
      if (pend) begin
        if (rsp_cnt == 0) begin dn_rvalid <= 1'b1; pend <= 1'b0; end
        else rsp_cnt <= rsp_cnt - 1;
      end
      if (dn_req && dn_ready) begin
        automatic int a = int'((dn_addr - SRC) & 32'hFF);
        automatic int n = 1 << dn_size;
        automatic logic e = (dn_addr == err_addr) &&
                            ((err_kind == 1 && !dn_we) || (err_kind == 2 && dn_we));
        automatic logic [31:0] d = '0;
        if (dn_we) begin
          wr_hs++; last_wr_addr <= dn_addr; last_wr_size <= dn_size;
          if (!e) for (int k = 0; k < n; k++) mem[(a + k) & 255] <= dn_wdata[8*k +: 8];
        end else begin
          rd_hs++; last_rd_addr <= dn_addr; last_rd_size <= dn_size;
          for (int k = 0; k < n; k++) d[8*k +: 8] = mem[(a + k) & 255];
        end
        dn_rdata <= d;
        dn_err   <= e;
        pend     <= 1'b1;
        rsp_cnt  <= hs_count % 2;
        rdy_wait <= 2'(hs_count % 3);
        hs_count++;
      end else if (dn_req && rdy_wait != 0) begin
        rdy_wait <= rdy_wait - 2'd1;
      end
    end
  end

  // Per-clock observation
  always @(negedge clk) begin
    if (!rst) begin
      if (!up_busy && dn_req) stray++;
      if (up_rsp_valid) rsp_pulses++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int src_index(input int off, input int sz);
    return (off >> 5) & ~((1 << sz) - 1);
  endfunction

  function automatic int bit_pos(input int off, input int sz);
    return (off >> 2) & ((8 << sz) - 1);
  endfunction

  task automatic access(input logic we, input logic [31:0] hi, input int off,
                        input int sz, input logic wb, input int ekind, input string tag);
    int sidx, pos, byt, bt, rd0, wr0, p0, guard;
    logic exp_b, exp_err;
    sidx = src_index(off, sz);
    pos  = bit_pos(off, sz);
    byt  = sidx + (pos >> 3);
    bt   = pos & 7;
    exp_b   = shadow[byt][bt];
    exp_err = (sz == 3) || (ekind != 0);
    err_kind = ekind;
    err_addr = SRC + 32'(sidx);
    rd0 = rd_hs; wr0 = wr_hs; p0 = rsp_pulses;
    @(negedge clk);
    up_req = 1'b1; up_we = we; up_addr = hi + 32'(off); up_size = 2'(sz);
    up_wdata = {31'h7FFF_FFFF, 1'b0} | {31'h0, wb};
    if (!wb) up_wdata = 32'hFFFF_FFFE;
    @(negedge clk);
    up_req = 1'b0;
    check(up_busy == 1'b1, "R9", {tag, " busy after accept"}, 32'(up_busy), 32'd1);
    guard = 0;
    while (!up_rsp_valid && guard < 200) begin @(negedge clk); guard++; end
    check(up_rsp_err == exp_err, exp_err ? (sz == 3 ? "R6" : (ekind == 1 ? "R7" : "R8")) : "R8",
          {tag, " error flag"}, 32'(up_rsp_err), 32'(exp_err));
    if (!we && !exp_err)
      check(up_rsp_rdata == 32'(exp_b), "R4", {tag, " read bit"}, up_rsp_rdata, 32'(exp_b));
    if (sz != 3) begin
      check(last_rd_addr == SRC + 32'(sidx), "R2", {tag, " source address"},
            last_rd_addr, SRC + 32'(sidx));
      check(last_rd_size == 2'(sz), "R6", {tag, " downstream size"},
            32'(last_rd_size), 32'(sz));
    end else begin
      check(rd_hs == rd0 && wr_hs == wr0, "R6", {tag, " no downstream traffic"},
            32'(rd_hs + wr_hs), 32'(rd0 + wr0));
    end
    if (ekind == 1 || !we)
      check(wr_hs == wr0, ekind == 1 ? "R7" : "R4", {tag, " no write issued"},
            32'(wr_hs), 32'(wr0));
    if (we && sz != 3 && ekind != 1) begin
      check(wr_hs == wr0 + 1 && last_wr_addr == SRC + 32'(sidx) && last_wr_size == 2'(sz),
            "R5", {tag, " write-back address"}, last_wr_addr, SRC + 32'(sidx));
      if (ekind == 0) shadow[byt][bt] = wb;
      for (int k = 0; k < (1 << sz); k++)
        check(mem[sidx + k] == shadow[sidx + k], "R3", {tag, " memory byte"},
              32'(mem[sidx + k]), 32'(shadow[sidx + k]));
    end
    @(negedge clk);
    check(!up_busy && rsp_pulses == p0 + 1, "R9", {tag, " idle after single response"},
          32'(rsp_pulses - p0), 32'd1);
    err_kind = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 256; i++) shadow[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(!up_busy, "R1", "busy after reset", 32'(up_busy), 0);
    check(!up_rsp_valid, "R1", "rsp after reset", 32'(up_rsp_valid), 0);
    check(!dn_req, "R1", "dn_req after reset", 32'(dn_req), 0);

    access(1'b0, ALIAS, 32'h0000, 0, 1'b0, 0, "R4 byte read");
    access(1'b0, ALIAS, 32'h007C, 2, 1'b0, 0, "R3 word read top bit");
    access(1'b0, ALIAS, 32'h1234, 1, 1'b0, 0, "R3 half read");
    access(1'b1, ALIAS, 32'h0244, 0, 1'b1, 0, "R5 byte set");
    access(1'b0, ALIAS, 32'h0244, 0, 1'b0, 0, "R5 readback set");
    access(1'b1, ALIAS, 32'h07E4, 2, 1'b0, 0, "R5 word clear");
    access(1'b0, ALIAS, 32'h07E4, 2, 1'b0, 0, "R5 readback clear");
    access(1'b1, ALIAS, 32'h0A3C, 1, 1'b1, 0, "R5 half set");
    access(1'b1, ALIAS, 32'h0400, 2, 1'b1, 1, "R7 read error on write");
    access(1'b0, ALIAS, 32'h0400, 0, 1'b0, 1, "R7 read error on read");
    access(1'b1, ALIAS, 32'h0810, 0, 1'b1, 2, "R8 write error");
    access(1'b0, ALIAS, 32'h0810, 0, 1'b0, 0, "R8 data unchanged");
    access(1'b0, ALIAS, 32'h0100, 3, 1'b0, 0, "R6 illegal size");
    access(1'b0, 32'h2600_0000, 32'h1234, 1, 1'b0, 0, "R2 upper bits ignored");
    access(1'b1, 32'h3E00_0000, 32'h0F3C, 2, 1'b1, 0, "R2 upper bits write");

    // R9: a request while busy is ignored
    begin : ignore_test
      int wr0, p0, guard;
      wr0 = wr_hs; p0 = rsp_pulses;
      @(negedge clk);
      up_req = 1'b1; up_we = 1'b0; up_addr = ALIAS + 32'h0020; up_size = 2'd0;
      @(negedge clk);
      up_req = 1'b1; up_we = 1'b1; up_addr = ALIAS + 32'h0C00; up_wdata = 32'h1;
      @(negedge clk);
      up_req = 1'b0;
      guard = 0;
      while (up_busy && guard < 200) begin @(negedge clk); guard++; end
      @(negedge clk);
      check(rsp_pulses == p0 + 1 && wr_hs == wr0, "R9", "request while busy ignored",
            32'(wr_hs - wr0), 0);
    end
    access(1'b0, ALIAS, 32'h0C00, 0, 1'b0, 0, "R9 target untouched");

    for (int i = 0; i < 40; i++) begin
      automatic int off = (i * 1237 + 88) % 8000;
      automatic int sz = i % 3;
      access(i % 2 == 1, ALIAS, off, sz, (i % 4) > 1, 0, "R5 mixed sweep");
    end

    begin : final_cmp
      int bad;
      bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] != shadow[i]) bad++;
      check(bad == 0, "R5", "whole memory matches model", 32'(bad), 0);
    end
    check(stray == 0, "R10", "no downstream request while idle", 32'(stray), 0);

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule